// File: doc/BRIEF.md
# Fault-Injectable Multiplexer with Exhaustive Detection Sweep

This block is an N-to-1 multiplexer of W-bit inputs that can be switched, on purpose, into one of several functional fault modes. It is intended for test experiments. In fault-free operation the data path is purely combinational and adds no latency. With the fault enable raised, a 3-bit mode code picks one of five faults:
- the output is stuck so that it can never show 0;
- the output is stuck so that it can never show 1;
- a wrong input is routed to the output;
- an extra input is merged with the correct one by wired-AND;
- an extra input is merged with the correct one by wired-OR.

A secondary select code names the wrong or extra input.

Next to the data path sits a registered sweep engine. It holds a golden copy and a faulty copy of the multiplexer. On a start pulse it steps through each faulty mode in turn. For every mode it applies every combination of data and primary select, one vector per clock. It compares the two copies and sets one sticky bit per mode as soon as that mode produced a mismatch. The secondary select for the sweep is taken from the same port as the data path's secondary select, and must be held stable while the sweep runs.

Top module: `fmux_top`

## Requirements
- R1: With fault_en_i low, or with mode code 000, y_o equals input sel_i in the same cycle. Input k occupies data_i[k*W +: W], and an out-of-range select gives all zeros.
- R2: With fault_en_i high and mode 001, every bit of y_o is 1, whatever the data and select.
- R3: With fault_en_i high and mode 010, every bit of y_o is 0, whatever the data and select.
- R4: With fault_en_i high and mode 011, y_o equals the input named by alt_sel_i instead of the one named by sel_i.
- R5: With fault_en_i high and mode 100, y_o is the bitwise AND of the inputs named by sel_i and alt_sel_i.
- R6: With fault_en_i high and mode 101, y_o is the bitwise OR of the inputs named by sel_i and alt_sel_i.
- R7: When alt_sel_i equals sel_i, modes 011, 100 and 101 give the fault-free output.
- R8: Mode codes 110 and 111 give the fault-free output.
- R9: After reset, sweep_busy_o, sweep_done_o and sweep_hit_o are all 0.
- R10: A sweep_start_i pulse while idle sets sweep_busy_o and clears sweep_hit_o and sweep_done_o at the next edge. Busy then stays high for exactly 6 * 2^(N_IN*W+SEL_W) cycles, and after that done is 1 and busy is 0.
- R11: Bit m of sweep_hit_o is set when faulty mode m differed from the golden copy on at least one sweep vector. Bit 0, the fault-free mode, is never set. With the defaults (N_IN=4, W=1), a completed sweep yields 6'b111110 for any secondary select.
- R12: sweep_start_i while busy is ignored: the running sweep keeps its length and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | N_IN*W | Packed data inputs, input k at bits k*W upward |
| sel_i | input | SEL_W | Primary select code |
| fault_en_i | input | 1 | Enables fault injection on the data path |
| mode_i | input | 3 | Fault mode code |
| alt_sel_i | input | SEL_W | Secondary select: wrong or extra input, also used by the sweep |
| y_o | output | W | Multiplexer output |
| sweep_start_i | input | 1 | Starts a detection sweep when idle |
| sweep_busy_o | output | 1 | Sweep in progress |
| sweep_done_o | output | 1 | Last sweep completed |
| sweep_hit_o | output | 6 | Per-mode detected flags, bit index = mode code |

## Verification
The data path has no register, so each combination of data, select, secondary select, enable and mode is applied, and y_o is sampled 1 ns later, before the next change, with the expected bit computed from shifts of the data word. The sweep outputs change only at rising edges. Start is driven at a falling edge, and busy and the cleared hit flags are checked at the next falling edge, one edge after start. Busy cycles are counted at falling edges until busy drops, and done and the hit vector are read at that same falling edge, since the final compare is registered at the edge that ends busy.

// File: rtl/fmux_pkg.sv
package fmux_pkg;
  localparam int MODE_W    = 3;
  localparam int NUM_MODES = 6;

  typedef enum logic [MODE_W-1:0] {
    FM_NONE   = 3'b000,
    FM_HI     = 3'b001,
    FM_LO     = 3'b010,
    FM_WRONG  = 3'b011,
    FM_EXTAND = 3'b100,
    FM_EXTOR  = 3'b101,
    FM_RSV6   = 3'b110,
    FM_RSV7   = 3'b111
  } fmode_e;
endpackage

// File: rtl/fmux_select.sv
module fmux_select #(
  parameter int N_IN  = 4,
  parameter int W     = 1,
  parameter int SEL_W = 2
) (
  input  logic [N_IN*W-1:0] data_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [W-1:0]      y_o
);
  logic [N_IN-1:0][W-1:0] term;

  // one-hot AND-OR tree; unmatched codes give zero
  for (genvar g = 0; g < N_IN; g++) begin : g_term
    assign term[g] = (sel_i == SEL_W'(g)) ? data_i[g*W +: W] : '0;
  end

  always_comb begin
    y_o = '0;
    for (int k = 0; k < N_IN; k++) y_o = y_o | term[k];
  end
endmodule

// File: rtl/fmux_fault.sv
module fmux_fault
  import fmux_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int W     = 1,
  parameter int SEL_W = 2
) (
  input  logic [N_IN*W-1:0] data_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [SEL_W-1:0]  alt_sel_i,
  input  logic              fault_en_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [W-1:0]      y_o
);
  logic [W-1:0] prim, sec;

  fmux_select #(.N_IN(N_IN), .W(W), .SEL_W(SEL_W)) i_prim (
    .data_i(data_i), .sel_i(sel_i), .y_o(prim)
  );
  fmux_select #(.N_IN(N_IN), .W(W), .SEL_W(SEL_W)) i_sec (
    .data_i(data_i), .sel_i(alt_sel_i), .y_o(sec)
  );

  always_comb begin
    y_o = prim;
    if (fault_en_i) begin
      unique case (fmode_e'(mode_i))
        FM_HI:     y_o = '1;
        FM_LO:     y_o = '0;
        FM_WRONG:  y_o = sec;
        FM_EXTAND: y_o = prim & sec;
        FM_EXTOR:  y_o = prim | sec;
        default:   y_o = prim;
      endcase
    end
  end
endmodule

// File: rtl/fmux_sweep.sv
module fmux_sweep
  import fmux_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int W     = 1,
  parameter int SEL_W = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [SEL_W-1:0]     alt_sel_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [NUM_MODES-1:0] hit_o
);
  localparam int DATA_W = N_IN * W;
  localparam int VEC_W  = DATA_W + SEL_W;

  logic [VEC_W-1:0]     vec_q;
  logic [MODE_W-1:0]    mode_q;
  logic                 busy_q, done_q;
  logic [NUM_MODES-1:0] hit_q, hit_d;
  logic [W-1:0]         gold_y, bad_y;
  logic                 miss, last_vec, last_mode;

  wire [SEL_W-1:0]  stim_sel  = vec_q[SEL_W-1:0];
  wire [DATA_W-1:0] stim_data = vec_q[VEC_W-1:SEL_W];

  fmux_fault #(.N_IN(N_IN), .W(W), .SEL_W(SEL_W)) i_gold (
    .data_i(stim_data), .sel_i(stim_sel), .alt_sel_i(alt_sel_i),
    .fault_en_i(1'b0), .mode_i(mode_q), .y_o(gold_y)
  );
  fmux_fault #(.N_IN(N_IN), .W(W), .SEL_W(SEL_W)) i_bad (
    .data_i(stim_data), .sel_i(stim_sel), .alt_sel_i(alt_sel_i),
    .fault_en_i(1'b1), .mode_i(mode_q), .y_o(bad_y)
  );

  assign miss      = busy_q && (gold_y != bad_y);
  assign last_vec  = (vec_q == '1);
  assign last_mode = (mode_q == MODE_W'(NUM_MODES - 1));

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_hit
    assign hit_d[m] = hit_q[m] | (miss && (mode_q == MODE_W'(m)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q  <= '0;
      mode_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      hit_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        vec_q  <= '0;
        mode_q <= '0;
        busy_q <= 1'b1;
        done_q <= 1'b0;
        hit_q  <= '0;
      end
    end else begin
      hit_q <= hit_d;
      vec_q <= vec_q + 1'b1;
      if (last_vec) begin
        if (last_mode) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          mode_q <= mode_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign hit_o  = hit_q;
endmodule

// File: rtl/fmux_top.sv
module fmux_top
  import fmux_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int W     = 1,
  parameter int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_IN*W-1:0]    data_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 fault_en_i,
  input  logic [2:0]           mode_i,
  input  logic [SEL_W-1:0]     alt_sel_i,
  output logic [W-1:0]         y_o,
  input  logic                 sweep_start_i,
  output logic                 sweep_busy_o,
  output logic                 sweep_done_o,
  output logic [5:0]           sweep_hit_o
);
  fmux_fault #(.N_IN(N_IN), .W(W), .SEL_W(SEL_W)) i_path (
    .data_i(data_i), .sel_i(sel_i), .alt_sel_i(alt_sel_i),
    .fault_en_i(fault_en_i), .mode_i(mode_i), .y_o(y_o)
  );

  fmux_sweep #(.N_IN(N_IN), .W(W), .SEL_W(SEL_W)) i_sweep (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(sweep_start_i),
    .alt_sel_i(alt_sel_i), .busy_o(sweep_busy_o),
    .done_o(sweep_done_o), .hit_o(sweep_hit_o)
  );
endmodule

// File: rtl/fmux_chk.sv
module fmux_chk #(
  parameter int N_IN  = 4,
  parameter int W     = 1,
  parameter int SEL_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_IN*W-1:0] data_i,
  input logic [SEL_W-1:0]  sel_i,
  input logic              fault_en_i,
  input logic [2:0]        mode_i,
  input logic [SEL_W-1:0]  alt_sel_i,
  input logic [W-1:0]      y_o,
  input logic              sweep_start_i,
  input logic              sweep_busy_o,
  input logic              sweep_done_o,
  input logic [5:0]        sweep_hit_o
);
  localparam int TOTAL = 6 * (2 ** (N_IN * W + SEL_W));

  function automatic logic [W-1:0] pick(input logic [N_IN*W-1:0] d,
                                        input logic [SEL_W-1:0] s);
    pick = '0;
    for (int k = 0; k < N_IN; k++)
      if (int'(s) == k) pick = d[k*W +: W];
  endfunction

  int run_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           run_cnt <= 0;
    else if (sweep_busy_o) run_cnt <= run_cnt + 1;
    else                   run_cnt <= 0;
  end

  p_free_path_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_en_i |-> y_o == pick(data_i, sel_i));

  p_never_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_en_i && mode_i == 3'b001) |-> y_o == '1);

  p_never_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_en_i && mode_i == 3'b010) |-> y_o == '0);

  p_same_alt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_en_i && alt_sel_i == sel_i && mode_i inside {3'b011, 3'b100, 3'b101})
      |-> y_o == pick(data_i, sel_i));

  p_start_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sweep_busy_o) |-> (sweep_hit_o == '0 && !sweep_done_o));

  p_run_len_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sweep_busy_o) |-> (run_cnt == TOTAL && sweep_done_o));

  p_free_no_hit_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sweep_hit_o[0]);

  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sweep_busy_o && !$past(sweep_busy_o)) |-> $stable(sweep_hit_o));
endmodule

bind fmux_top fmux_chk #(.N_IN(N_IN), .W(W), .SEL_W(SEL_W)) i_fmux_chk (.*);

// File: tb/test_fmux_top.sv
`timescale 1ns/1ps
module test_fmux_top;
  localparam int N_IN  = 4;
  localparam int W     = 1;
  localparam int SEL_W = 2;
  localparam int TOTAL = 6 * 64;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [N_IN*W-1:0] data_i = '0;
  logic [SEL_W-1:0]  sel_i = '0, alt_sel_i = '0;
  logic              fault_en_i = 1'b0;
  logic [2:0]        mode_i = '0;
  logic [W-1:0]      y_o;
  logic              sweep_start_i = 1'b0;
  logic              sweep_busy_o, sweep_done_o;
  logic [5:0]        sweep_hit_o;

  int checks = 0, errors = 0;

  always #10 clk_i = ~clk_i;

  fmux_top #(.N_IN(N_IN), .W(W)) i_fmux_top (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic model(input logic [3:0] d, input int s, input int a,
                                 input logic en, input int m);
    logic p, q;
    p = d[s];
    q = d[a];
    if (!en) return p;
    case (m)
      1: return 1'b1;
      2: return 1'b0;
      3: return q;
      4: return p & q;
      5: return p | q;
      default: return p;
    endcase
  endfunction

  function automatic string tag(input logic en, input int m, input int s, input int a);
    if (!en || m == 0) return "R1";
    if (m >= 6) return "R8";
    if (m >= 3 && s == a) return "R7";
    case (m)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic run_sweep(input int alt, input bit restart_mid);
    int busy_cycles;
    alt_sel_i = SEL_W'(alt);
    @(negedge clk_i);
    sweep_start_i = 1'b1;
    @(negedge clk_i);
    sweep_start_i = 1'b0;
    check("R10 busy after start", 32'(sweep_busy_o), 1);
    check("R10 hit cleared", 32'(sweep_hit_o), 0);
    check("R10 done cleared", 32'(sweep_done_o), 0);
    busy_cycles = 1;
    while (sweep_busy_o) begin
      if (restart_mid && busy_cycles == 100) sweep_start_i = 1'b1; // R12
      @(negedge clk_i);
      sweep_start_i = 1'b0;
      if (sweep_busy_o) busy_cycles++;
    end
    check(restart_mid ? "R12 length" : "R10 length", 32'(busy_cycles), TOTAL);
    check("R10 done", 32'(sweep_done_o), 1);
    check(restart_mid ? "R12 hits" : "R11 hits", 32'(sweep_hit_o), 32'h3e);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #35;
    check("R9 busy", 32'(sweep_busy_o), 0);
    check("R9 done", 32'(sweep_done_o), 0);
    check("R9 hit", 32'(sweep_hit_o), 0);
    rst_ni = 1'b1;

    // combinational path: every data, select, alt, enable and mode code
    for (int en = 0; en < 2; en++)
      for (int m = 0; m < 8; m++)
        for (int a = 0; a < N_IN; a++)
          for (int s = 0; s < N_IN; s++)
            for (int d = 0; d < 16; d++) begin
              data_i = 4'(d);
              sel_i = SEL_W'(s);
              alt_sel_i = SEL_W'(a);
              fault_en_i = en[0];
              mode_i = 3'(m);
              #1;
              check(tag(en[0], m, s, a), 32'(y_o),
                    32'(model(4'(d), s, a, en[0], m)));
            end
    fault_en_i = 1'b0;
    mode_i = '0;

    @(negedge clk_i);
    check("R9 idle hit", 32'(sweep_hit_o), 0);
    run_sweep(2, 1'b0);
    // idle: no change after sweep
    @(negedge clk_i);
    check("R11 idle hold", 32'(sweep_hit_o), 32'h3e);
    check("R11 idle busy", 32'(sweep_busy_o), 0);
    run_sweep(0, 1'b1);
    run_sweep(3, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule